// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches one external interrupt pin on behalf of a small CPU and holds an interrupt request flag for it. The raw pin is brought into the clock domain by a synchronizer chain. It is then gated by an input-enable control and adjusted by a polarity control. The resulting qualified level is registered, and a rise of that qualified level counts as an event. An event sets the request flag. It also produces a one-cycle wakeup pulse when wakeup is enabled.

Event detection runs on the gated, polarity-adjusted level and not on the raw pin. As a result, a write to the input-enable or polarity control can raise the flag by itself when the pin already sits at the newly active level. Software is expected to mask the interrupt, change the configuration, and then issue a test-and-clear command at least one cycle later. The test-and-clear command reports the flag as a skip indication and clears it. An interrupt acknowledge from the CPU also clears it. When a new event arrives in the same cycle as a clear, the flag stays set.

Top module: `extint_detect`

## Requirements
- R1: While reset is asserted and in the cycle after it, irq_o, skip_o and wake_o are 0.
- R2: With input enabled, a pin change that makes the qualified level active is reflected on irq_o (interrupt enabled) exactly SYNC_STAGES+1 rising edges after the pin changes, and not earlier.
- R3: With cfg_pol_i = 1 only a low-to-high pin transition sets the flag; with cfg_pol_i = 0 only a high-to-low transition does.
- R4: With cfg_in_en_i = 0, pin transitions in either direction never set the flag.
- R5: Setting cfg_in_en_i from 0 to 1 sets the flag at the next edge when the synchronized pin equals cfg_pol_i, and not otherwise.
- R6: Changing cfg_pol_i with input enabled sets the flag at the next edge when the new polarity equals the synchronized pin; a change that makes the qualified level inactive sets nothing.
- R7: irq_o is high only while the flag is set and cfg_ie_i is 1; clearing cfg_ie_i drops irq_o in the same cycle without clearing the flag.
- R8: A test_clr_i cycle makes skip_o 1 in the following cycle if the flag was set and 0 if it was clear, and leaves the flag clear.
- R9: An event and a test_clr_i in the same cycle leave the flag set (skip_o reports the old value 0); a test_clr_i one cycle later clears it.
- R10: irq_ack_i clears the flag at the next edge.
- R11: With cfg_wake_en_i = 1, each event produces a one-cycle wake_o pulse in the same cycle that the flag becomes set, even with cfg_ie_i = 0; with cfg_wake_en_i = 0, wake_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin |
| cfg_in_en_i | input | 1 | Pin input enable (0 blocks the pin) |
| cfg_pol_i | input | 1 | Active polarity: 1 rising, 0 falling |
| cfg_ie_i | input | 1 | Interrupt enable towards the CPU |
| cfg_wake_en_i | input | 1 | Wakeup enable |
| test_clr_i | input | 1 | Test-and-clear command, one cycle |
| irq_ack_i | input | 1 | CPU interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| skip_o | output | 1 | Result of test-and-clear, one cycle after the command |
| wake_o | output | 1 | Wakeup request pulse |

## Verification
The collision of interest is between a flag set and a flag clear in one cycle. It is provoked by raising the input enable with the pin already at the active level while test_clr_i is high in that same cycle. The bench expects skip_o to report 0, since the flag was clear before that edge. A second test-and-clear must then report 1, and a third must report 0, which shows that the set won and that the later command cleared the flag. Acknowledge and event timing are judged the same way, at the exact edge counted from the synchronizer depth.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef struct packed {
        logic lvl;
    } qual_state_t;

    typedef struct packed {
        logic flag;
        logic skip;
        logic wake;
    } flag_state_t;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_s_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = pin_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], pin_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_s_o = sync_q[STAGES-1];
endmodule

// File: rtl/extint_qual.sv
module extint_qual
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    input  logic in_en_i,
    input  logic pol_i,
    output logic evt_o
);
    qual_state_t st_d, st_q;
    logic        level;

    always_comb begin
        level      = in_en_i & ~(pin_s_i ^ pol_i);
        st_d       = st_q;
        st_d.lvl   = level;
        evt_o      = level & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/extint_flag.sv
module extint_flag
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic test_clr_i,
    input  logic ack_i,
    input  logic ie_i,
    input  logic wake_en_i,
    output logic irq_o,
    output logic skip_o,
    output logic wake_o,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.skip = test_clr_i & st_q.flag;
        st_d.wake = wake_en_i & evt_i;
        if (evt_i)                   st_d.flag = 1'b1;
        else if (test_clr_i || ack_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.flag & ie_i;
    assign skip_o = st_q.skip;
    assign wake_o = st_q.wake;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/extint_detect.sv
module extint_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic cfg_in_en_i,
    input  logic cfg_pol_i,
    input  logic cfg_ie_i,
    input  logic cfg_wake_en_i,
    input  logic test_clr_i,
    input  logic irq_ack_i,
    output logic irq_o,
    output logic skip_o,
    output logic wake_o
);
    logic pin_s_w;
    logic evt_w;
    logic flag_w;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .pin_s_o (pin_s_w)
    );

    extint_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pin_s_w),
        .in_en_i (cfg_in_en_i),
        .pol_i   (cfg_pol_i),
        .evt_o   (evt_w)
    );

    extint_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .test_clr_i (test_clr_i),
        .ack_i      (irq_ack_i),
        .ie_i       (cfg_ie_i),
        .wake_en_i  (cfg_wake_en_i),
        .irq_o      (irq_o),
        .skip_o     (skip_o),
        .wake_o     (wake_o),
        .flag_o     (flag_w)
    );
endmodule

// File: rtl/extint_checker.sv
module extint_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_ie_i,
    input logic cfg_wake_en_i,
    input logic test_clr_i,
    input logic irq_ack_i,
    input logic irq_o,
    input logic skip_o,
    input logic wake_o,
    input logic evt,
    input logic flag
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !skip_o && !wake_o));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cfg_ie_i);

    p_skip_from_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> $past(test_clr_i));

    p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_clr_i && !evt) |=> !flag);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !evt) |=> !flag);

    p_wake_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(cfg_wake_en_i) && flag));
endmodule

bind extint_detect extint_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ie_i      (cfg_ie_i),
    .cfg_wake_en_i (cfg_wake_en_i),
    .test_clr_i    (test_clr_i),
    .irq_ack_i     (irq_ack_i),
    .irq_o         (irq_o),
    .skip_o        (skip_o),
    .wake_o        (wake_o),
    .evt           (evt_w),
    .flag          (flag_w)
);

// File: tb/test_extint_detect.sv
module test_extint_detect;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, in_en = 1'b0, pol = 1'b0, ie = 1'b0, wake_en = 1'b0;
    logic test_clr = 1'b0, ack = 1'b0;
    logic irq, skip, wake;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #5ns clk = ~clk;

    extint_detect #(.SYNC_STAGES(SYNC)) i_extint_detect (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_in_en_i(in_en),
        .cfg_pol_i(pol), .cfg_ie_i(ie), .cfg_wake_en_i(wake_en),
        .test_clr_i(test_clr), .irq_ack_i(ack),
        .irq_o(irq), .skip_o(skip), .wake_o(wake)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic settle();
        repeat (SYNC + 2) tick();
    endtask

    task automatic clear_flag();
        test_clr = 1'b1; tick(); test_clr = 1'b0; tick();
    endtask

    task automatic probe(input logic exp, input string req);
        test_clr = 1'b1; tick(); test_clr = 1'b0;
        check(skip, exp, req);
        tick();
        check(skip, 1'b0, {req, " skip pulse ends"});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2ms;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        check(irq, 1'b0, "R1 irq"); check(skip, 1'b0, "R1 skip"); check(wake, 1'b0, "R1 wake");
        rst_n = 1'b1; tick();
        check(irq, 1'b0, "R1 irq after"); check(skip, 1'b0, "R1 skip after");
        check(wake, 1'b0, "R1 wake after");

        // R3 polarity sweep
        in_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int start = 0; start < 2; start++) begin
                pol = p[0]; pin = start[0]; settle(); clear_flag();
                pin = ~start[0]; settle();
                probe(((~start[0]) == p[0]), "R3 polarity sweep");
            end
        end

        // R8 empty test reports zero
        probe(1'b0, "R8 empty flag");

        // R4 input disabled
        in_en = 1'b0; ie = 1'b1;
        for (int p = 0; p < 2; p++) begin
            pol = p[0]; pin = 1'b0; settle(); clear_flag();
            pin = 1'b1; settle(); check(irq, 1'b0, "R4 irq rise");
            pin = 1'b0; settle(); check(irq, 1'b0, "R4 irq fall");
            probe(1'b0, "R4 disabled");
        end
        ie = 1'b0;

        // R5 enabling input sweep
        for (int p = 0; p < 2; p++) begin
            for (int q = 0; q < 2; q++) begin
                in_en = 1'b0; pin = p[0]; pol = q[0]; settle(); clear_flag();
                in_en = 1'b1; tick();
                probe((p == q), "R5 enable sweep");
            end
        end

        // R6 polarity change
        for (int p = 0; p < 2; p++) begin
            in_en = 1'b1; pin = p[0]; pol = ~p[0]; settle(); clear_flag();
            pol = p[0]; tick();
            probe(1'b1, "R6 pol to active");
            pol = ~p[0]; tick();
            probe(1'b0, "R6 pol to inactive");
        end

        // R2 / R7 timing and masking
        in_en = 1'b1; pol = 1'b1; pin = 1'b0; ie = 1'b0; settle(); clear_flag();
        ie = 1'b1; pin = 1'b1;
        repeat (SYNC) tick();
        check(irq, 1'b0, "R2 not early");
        tick();
        check(irq, 1'b1, "R2 on time");
        ie = 1'b0; #1ns;
        check(irq, 1'b0, "R7 masked");
        probe(1'b1, "R7 flag kept");

        // R9 set vs clear collision
        in_en = 1'b0; pol = 1'b1; pin = 1'b1; settle(); clear_flag();
        in_en = 1'b1; test_clr = 1'b1; tick(); test_clr = 1'b0;
        check(skip, 1'b0, "R9 old value");
        tick();
        probe(1'b1, "R9 set wins");
        probe(1'b0, "R9 later clear");

        // R10 acknowledge
        pin = 1'b0; settle(); clear_flag();
        pin = 1'b1; settle();
        ack = 1'b1; tick(); ack = 1'b0;
        probe(1'b0, "R10 ack clears");

        // R11 wakeup
        wake_en = 1'b1; ie = 1'b0; pin = 1'b0; settle(); clear_flag();
        pin = 1'b1;
        repeat (SYNC) tick();
        check(wake, 1'b0, "R11 not early");
        tick();
        check(wake, 1'b1, "R11 pulse");
        tick();
        check(wake, 1'b0, "R11 one cycle");
        wake_en = 1'b0; pin = 1'b0; settle(); clear_flag();
        pin = 1'b1;
        for (int i = 0; i < SYNC + 3; i++) begin
            tick();
            check(wake, 1'b0, "R11 disabled");
        end
        probe(1'b1, "R11 flag still set");

        summary();
    end
endmodule